// File: doc/BRIEF.md
# Microwire EEPROM Boot Loader with Image Checksum

After a start pulse, this block copies a fixed block of 16-bit words out of a three-wire Microwire serial EEPROM into a local word array. It then checks the integrity of the copy. The EEPROM pins are shared with another agent, so the loader first asks an arbiter for the pins. It raises a request line and polls the grant input a bounded number of times at a fixed spacing. If the grant never comes, the loader gives up and reports a timeout.

Once the pins are granted, the loader reads words 0 to N_WORDS-1 in ascending order. For each word it raises chip select and shifts out the read opcode `110` and the word address, most significant bit first. It then clocks 16 data bits in, also most significant bit first. The address is 6 bits wide for the small device and 8 bits wide when the size-select input is high. Each word is written to the array port as it arrives, and a running 16-bit sum is kept. When the loader finishes it drops the request, raises `done`, and sets `ok` only when the wrap-around sum equals the signature 0xBABA.

The control is a single state machine with five states:
- `ST_IDLE` moves to `ST_ARB` on start.
- `ST_ARB` moves to `ST_SHIFT` when a poll sees the grant, and to `ST_FIN` when the polls run out.
- `ST_SHIFT` moves to `ST_GAP` after the last data bit of a word.
- `ST_GAP` moves back to `ST_SHIFT` for the next word, or to `ST_FIN` after the last word.
- `ST_FIN` returns to `ST_IDLE`.

The serial clock comes from the system clock: each half period lasts SK_HALF cycles.

Top module: `eeprom_boot_loader`

## Requirements
- R1: After reset, `acc_req`, `ee_cs`, `ee_sk`, `ee_di`, `img_we`, `done`, `ok` and `gnt_timeout` are all 0.
- R2: A start pulse seen in `ST_IDLE` raises `acc_req`. `ee_cs` stays low until a poll has seen `acc_gnt` high, and `ee_cs` is never high while `acc_req` is low.
- R3: The grant is polled at most POLL_LIMIT times, POLL_GAP cycles apart, with the first poll in the first request cycle. If no poll sees the grant, `done`=1, `gnt_timeout`=1 and `ok`=0. In that case no word is read, and `acc_req` stays high for exactly (POLL_LIMIT-1)*POLL_GAP+2 cycles.
- R4: Each frame holds `ee_cs` high while `ee_di` carries the opcode bits 1,1,0 and then the address, MSB first. `ee_di` changes only while `ee_sk` is low. The device captures `ee_di` on each rising edge of `ee_sk`.
- R5: The address field is 6 bits wide when `big_dev` is 0 and 8 bits wide when `big_dev` is 1. `big_dev` is sampled with the start pulse.
- R6: After the last address bit, 16 more rising edges follow. On the k-th of these (k = 0..15), the device presents data bit 15-k. The loader samples `ee_do` at the end of each high phase and assembles the word MSB first.
- R7: Words 0 through N_WORDS-1 are read in ascending order. Each completed word is written once through `img_we`/`img_addr`/`img_data`, with `img_addr` equal to the word number.
- R8: Between two frames `ee_cs` stays low for exactly SK_HALF cycles.
- R9: After the last word, `done`=1, `gnt_timeout`=0, and `ok`=1 exactly when the 16-bit wrap-around sum of all words equals 0xBABA.
- R10: `acc_req` is low once `done` is high, on a pass, a checksum fail or a timeout.
- R11: Each high phase and each low phase of `ee_sk` inside a frame lasts SK_HALF system clock cycles.
- R12: A start pulse while a load is in progress has no effect: the load still reads exactly N_WORDS frames and `done` rises once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a load |
| big_dev | input | 1 | Size select: 1 = 8-bit address, 0 = 6-bit address |
| acc_req | output | 1 | Request for the shared EEPROM pins |
| acc_gnt | input | 1 | Grant of the shared EEPROM pins |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| img_we | output | 1 | Word-array write strobe |
| img_addr | output | $clog2(N_WORDS) | Word-array write address |
| img_data | output | WORD_W | Word-array write data |
| done | output | 1 | Load finished; held until the next accepted start |
| ok | output | 1 | Image checksum matched the signature |
| gnt_timeout | output | 1 | The grant never arrived |

## Verification
The bound checker watches, on every cycle, the pin-level rules of the serial interface:
- chip select only under the request and the serial clock only under chip select;
- data-in held through every high phase;
- chip select falling only together with a word write;
- the request dropped whenever `done` is set;
- `ok` never raised together with a timeout.

Only the bench scenarios can show the rest. A behavioural EEPROM in the bench decodes the opcode and address width, and it checks the ascending address sequence. It also compares the image against the stored contents and measures the exact phase and gap lengths. The scenarios cover the request duration on a timeout, the checksum verdict on good and corrupted images, and a start pulse ignored mid-load.

// File: rtl/ebl_pkg.sv
package ebl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_SHIFT,
        ST_GAP,
        ST_FIN
    } ebl_state_e;

    localparam logic [2:0] RD_OPCODE = 3'b110;
endpackage

// File: rtl/ebl_tick.sv
module ebl_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= RELOAD;
        end else if (cnt == '0) begin
            cnt <= RELOAD;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ebl_grant.sv
module ebl_grant #(
    parameter int LIMIT = 1000,
    parameter int GAP   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic gnt,
    output logic granted,
    output logic expired
);
    localparam int PW = $clog2(LIMIT + 1);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;

    logic [PW-1:0] polls;
    logic [GW-1:0] gap;
    logic          poll;

    assign poll    = active && (gap == '0);
    assign granted = poll && gnt;
    assign expired = poll && !gnt && (polls == PW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            polls <= '0;
            gap   <= '0;
        end else if (poll) begin
            if (!gnt && !expired) begin
                polls <= polls + 1'b1;
                gap   <= GW'(GAP - 1);
            end
        end else begin
            gap <= gap - 1'b1;
        end
    end
endmodule

// File: rtl/ebl_csum.sv
module ebl_csum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] val,
    output logic [W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + val;
        end
    end
endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
    import ebl_pkg::*;
#(
    parameter int SK_HALF    = 4,
    parameter int POLL_LIMIT = 1000,
    parameter int POLL_GAP   = 500,
    parameter int N_WORDS    = 64,
    parameter int WORD_W     = 16,
    parameter int AW_SMALL   = 6,
    parameter int AW_LARGE   = 8,
    parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       big_dev,
    output logic                       acc_req,
    input  logic                       acc_gnt,
    output logic                       ee_sk,
    output logic                       ee_cs,
    output logic                       ee_di,
    input  logic                       ee_do,
    output logic                       img_we,
    output logic [$clog2(N_WORDS)-1:0] img_addr,
    output logic [WORD_W-1:0]          img_data,
    output logic                       done,
    output logic                       ok,
    output logic                       gnt_timeout
);
    localparam int IW    = $clog2(N_WORDS);
    localparam int CMD_S = 3 + AW_SMALL;
    localparam int CMD_L = 3 + AW_LARGE;
    localparam int BW    = $clog2(CMD_L + WORD_W + 1);

    ebl_state_e state_q, state_d;

    logic              tick, granted, expired, word_done, last_word;
    logic              size_q, tmo_q, next_di, sum_clr;
    logic [IW-1:0]     word_idx;
    logic [BW-1:0]     bit_idx, nb, cmd_len, last_bit;
    logic [WORD_W-1:0] shreg, sum, rx_word;
    logic [CMD_L-1:0]  cmd_vec, cmd_sh;

    ebl_tick #(.HALF(SK_HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q == ST_SHIFT || state_q == ST_GAP),
        .tick (tick)
    );

    ebl_grant #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) u_grant (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_ARB),
        .gnt    (acc_gnt),
        .granted(granted),
        .expired(expired)
    );

    assign sum_clr = (state_q == ST_IDLE) && start;

    ebl_csum #(.W(WORD_W)) u_csum (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sum_clr),
        .add  (word_done),
        .val  (rx_word),
        .sum  (sum)
    );

    // frame geometry
    assign cmd_len   = size_q ? BW'(CMD_L) : BW'(CMD_S);
    assign last_bit  = cmd_len + BW'(WORD_W - 1);
    assign last_word = (word_idx == IW'(N_WORDS - 1));
    assign nb        = bit_idx + 1'b1;
    assign rx_word   = {shreg[WORD_W-2:0], ee_do};
    assign word_done = (state_q == ST_SHIFT) && tick && ee_sk && (bit_idx == last_bit);

    always_comb begin
        if (size_q) begin
            cmd_vec = {RD_OPCODE, AW_LARGE'(word_idx)};
        end else begin
            cmd_vec = CMD_L'({RD_OPCODE, AW_SMALL'(word_idx)}) << (AW_LARGE - AW_SMALL);
        end
        cmd_sh  = cmd_vec << nb;
        next_di = (nb < cmd_len) ? cmd_sh[CMD_L-1] : 1'b0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ARB;
            ST_ARB: begin
                if (granted)      state_d = ST_SHIFT;
                else if (expired) state_d = ST_FIN;
            end
            ST_SHIFT: if (word_done) state_d = ST_GAP;
            ST_GAP: begin
                if (tick) state_d = last_word ? ST_FIN : ST_SHIFT;
            end
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_req     <= 1'b0;
            ee_sk       <= 1'b0;
            ee_cs       <= 1'b0;
            ee_di       <= 1'b0;
            img_we      <= 1'b0;
            img_addr    <= '0;
            img_data    <= '0;
            done        <= 1'b0;
            ok          <= 1'b0;
            gnt_timeout <= 1'b0;
            size_q      <= 1'b0;
            tmo_q       <= 1'b0;
            word_idx    <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
        end else begin
            img_we <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        acc_req     <= 1'b1;
                        done        <= 1'b0;
                        ok          <= 1'b0;
                        gnt_timeout <= 1'b0;
                        size_q      <= big_dev;
                        tmo_q       <= 1'b0;
                        word_idx    <= '0;
                    end
                end
                ST_ARB: begin
                    if (granted) begin
                        ee_cs   <= 1'b1;
                        ee_sk   <= 1'b0;
                        ee_di   <= RD_OPCODE[2];
                        bit_idx <= '0;
                    end else if (expired) begin
                        tmo_q <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!ee_sk) begin
                            ee_sk <= 1'b1;
                        end else begin
                            ee_sk <= 1'b0;
                            if (bit_idx >= cmd_len) shreg <= rx_word;
                            if (word_done) begin
                                ee_cs    <= 1'b0;
                                ee_di    <= 1'b0;
                                img_we   <= 1'b1;
                                img_addr <= word_idx;
                                img_data <= rx_word;
                            end else begin
                                bit_idx <= nb;
                                ee_di   <= next_di;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick && !last_word) begin
                        word_idx <= word_idx + 1'b1;
                        ee_cs    <= 1'b1;
                        ee_di    <= RD_OPCODE[2];
                        bit_idx  <= '0;
                    end
                end
                ST_FIN: begin
                    acc_req     <= 1'b0;
                    done        <= 1'b1;
                    gnt_timeout <= tmo_q;
                    ok          <= !tmo_q && (sum == SIGNATURE);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ebl_chk.sv
module ebl_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_req,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di,
    input logic img_we,
    input logic done,
    input logic ok,
    input logic gnt_timeout
);
    // R2
    cs_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> acc_req);

    // R4
    sk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    // R4
    di_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> $stable(ee_di));

    // R7
    cs_fall_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> img_we);

    // R10
    req_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !acc_req);

    // R3
    timeout_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_timeout |-> !ok);
endmodule

bind eeprom_boot_loader ebl_chk u_ebl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_req    (acc_req),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .ee_di      (ee_di),
    .img_we     (img_we),
    .done       (done),
    .ok         (ok),
    .gnt_timeout(gnt_timeout)
);

// File: tb/eeprom_boot_loader_bench.sv
module eeprom_boot_loader_bench;
    localparam int SKH = 3;
    localparam int PL  = 8;
    localparam int PG  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic big_dev = 1'b0;
    logic acc_gnt = 1'b0;
    logic ee_do = 1'b0;
    logic acc_req, ee_sk, ee_cs, ee_di, img_we, done, ok, gnt_timeout;
    logic [5:0]  img_addr;
    logic [15:0] img_data;

    eeprom_boot_loader #(.SK_HALF(SKH), .POLL_LIMIT(PL), .POLL_GAP(PG)) u_eeprom_boot_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .big_dev(big_dev),
        .acc_req(acc_req), .acc_gnt(acc_gnt),
        .ee_sk(ee_sk), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do(ee_do),
        .img_we(img_we), .img_addr(img_addr), .img_data(img_data),
        .done(done), .ok(ok), .gnt_timeout(gnt_timeout)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    logic [15:0] mem [64];
    logic [15:0] got [64];
    int cmdw = 9, gnt_after = 0;
    int frames, op_err, a_err, wr_cnt, wr_err, hi_min, hi_max, hi_run;
    int gap_min, gap_run, req_cycles, req_at_cs, done_rises;
    int k, cur_addr;
    logic [15:0] cmd;
    logic prev_sk = 1'b0, prev_cs = 1'b0, prev_done = 1'b0, in_gap = 1'b0;

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] img_sum();
        logic [15:0] s = '0;
        for (int i = 0; i < 64; i++) s = s + mem[i];
        return s;
    endfunction

    // EEPROM model, arbiter model and monitors, all at the falling clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_req) req_cycles++;
            acc_gnt = acc_req && (gnt_after >= 0) && (req_cycles >= gnt_after);
            if (done && !prev_done) done_rises++;
            if (img_we) begin
                got[img_addr] = img_data;
                if (int'(img_addr) != wr_cnt) wr_err++;
                wr_cnt++;
            end
            if (prev_cs && !ee_cs) begin frames++; in_gap = 1'b1; gap_run = 0; end
            if (!ee_cs && in_gap) gap_run++;
            if (!prev_cs && ee_cs) begin
                if (in_gap && gap_run < gap_min) gap_min = gap_run;
                if (req_at_cs < 0) req_at_cs = req_cycles;
                in_gap = 1'b0;
                k = 0;
                cmd = '0;
            end
            if (ee_sk) hi_run++;
            else if (prev_sk) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                hi_run = 0;
            end
            if (ee_cs && ee_sk && !prev_sk) begin
                if (k < cmdw) begin
                    cmd = {cmd[14:0], ee_di};
                    k++;
                    if (k == cmdw) begin
                        if (cmd[cmdw-1 -: 3] != 3'b110) op_err++;
                        cur_addr = int'(cmd & 16'((1 << (cmdw - 3)) - 1));
                        if (cur_addr != frames) a_err++;
                    end
                end else begin
                    if (k - cmdw < 16) ee_do = mem[cur_addr % 64][15 - (k - cmdw)];
                    k++;
                end
            end
            prev_sk = ee_sk;
            prev_cs = ee_cs;
            prev_done = done;
        end
    end

    task automatic run(input bit big, input int gafter, input bit extra_start);
        int w;
        big_dev = big;
        cmdw = big ? 11 : 9;
        gnt_after = gafter;
        frames = 0; op_err = 0; a_err = 0; wr_cnt = 0; wr_err = 0;
        hi_min = 1000; hi_max = 0; hi_run = 0; gap_min = 1000; gap_run = 0;
        req_cycles = 0; req_at_cs = -1; done_rises = 0; in_gap = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra_start) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        w = 0;
        while (!done && w < 40000) begin @(negedge clk); w++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_good_run(input string name, input int gafter);
        int mism = 0;
        logic exp_ok;
        exp_ok = (img_sum() == 16'hBABA);
        for (int i = 0; i < 64; i++) if (got[i] !== mem[i]) mism++;
        check(done === 1'b1, {name, " R9 done"}, int'(done), 1);
        check(ok === exp_ok, {name, " R9 ok"}, int'(ok), int'(exp_ok));
        check(gnt_timeout === 1'b0, {name, " R9 no timeout"}, int'(gnt_timeout), 0);
        check(acc_req === 1'b0, {name, " R10 req released"}, int'(acc_req), 0);
        check(frames == 64, {name, " R7 frames"}, frames, 64);
        check(wr_cnt == 64 && wr_err == 0, {name, " R7 write order"}, wr_err, 0);
        check(op_err == 0, {name, " R4 opcode"}, op_err, 0);
        check(a_err == 0, {name, " R5 address"}, a_err, 0);
        check(mism == 0, {name, " R6 image"}, mism, 0);
        check(hi_min == SKH && hi_max == SKH, {name, " R11 sk high"}, hi_max, SKH);
        check(gap_min == SKH, {name, " R8 cs gap"}, gap_min, SKH);
        check(req_at_cs > gafter, {name, " R2 cs after grant"}, req_at_cs, gafter + 1);
        check(done_rises == 1, {name, " R12 single done"}, done_rises, 1);
    endtask

    task automatic fill_random(input bit make_good);
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        if (make_good) mem[63] = mem[63] + (16'hBABA - img_sum());
        else if (img_sum() == 16'hBABA) mem[0] = mem[0] + 16'd1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd20240));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(acc_req === 0 && ee_cs === 0 && ee_sk === 0 && ee_di === 0,
              "R1 pins idle", int'({acc_req, ee_cs, ee_sk, ee_di}), 0);
        check(done === 0 && ok === 0 && gnt_timeout === 0 && img_we === 0,
              "R1 status idle", int'({done, ok, gnt_timeout, img_we}), 0);

        fill_random(1'b1);
        run(1'b0, 0, 1'b0);
        check_good_run("small good", 0);

        fill_random(1'b1);
        run(1'b1, 3 * PG + 1, 1'b0);
        check_good_run("large good late grant", 3 * PG + 1);

        fill_random(1'b0);
        run(1'b0, 2, 1'b0);
        check_good_run("small bad sum", 2);

        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
        run(1'b1, 0, 1'b0);
        check_good_run("large all ones", 0);

        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[0] = 16'hBABA;
        run(1'b1, 0, 1'b1);
        check_good_run("large single word busy start", 0);

        // R3 timeout
        run(1'b0, -1, 1'b0);
        check(done === 1'b1 && gnt_timeout === 1'b1, "R3 timeout flagged",
              int'({done, gnt_timeout}), 3);
        check(ok === 1'b0, "R3 timeout not ok", int'(ok), 0);
        check(frames == 0 && wr_cnt == 0 && req_at_cs < 0, "R3 no frames", frames, 0);
        check(req_cycles == (PL - 1) * PG + 2, "R3 request duration",
              req_cycles, (PL - 1) * PG + 2);
        check(acc_req === 1'b0, "R10 released after timeout", int'(acc_req), 0);

        fill_random(1'b1);
        run(1'b0, (PL - 1) * PG, 1'b1);
        check_good_run("small last poll grant R12", (PL - 1) * PG);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule